// File: doc/BRIEF.md
# Serial Memory Word Address Pointer

This block keeps the byte address that a serial non-volatile memory uses for its next access. The protocol engine loads a new address as two bytes, a high byte and a low byte, each on its own strobe. After each byte transfer it pulses one of two increment strobes. The pointer keeps its value between transactions, so a later read with no address phase starts one past the last byte that was touched.

Writes and reads advance the pointer in different ways. A write step only counts the five low bits, so a burst of writes wraps around inside its own 32-byte page and the page row does not change. A read step counts the whole address, so a long read runs across page boundaries and wraps from the top of the array back to address zero. The address width is a parameter. With the default of 13 bits the array is 256 pages of 32 bytes.

Top module: `word_ptr_ctr`

## Requirements
- R1: When `rst_n` is low, `ptr` is 0. It stays 0 until the first strobe after reset is released.
- R2: In a cycle with no load strobe and no increment strobe, `ptr` keeps its value.
- R3: `inc_wr` on its own adds 1 modulo 32 to bits [4:0] and leaves bits [ADDR_W-1:5] unchanged. Example: 0x031F steps to 0x0300.
- R4: `inc_rd` on its own adds 1 modulo 2^ADDR_W to the whole pointer. It crosses page boundaries, for example 0x031F steps to 0x0320, and it wraps 0x1FFF to 0x0000.
- R5: `ld_lo_en` copies `ld_byte` into bits [7:0] of `ptr` and keeps bits [ADDR_W-1:8].
- R6: `ld_hi_en` copies `ld_byte[ADDR_W-9:0]` into bits [ADDR_W-1:8] of `ptr` and keeps bits [7:0]. The bits of `ld_byte` above ADDR_W-9 have no effect.
- R7: In any cycle with a load strobe, both increment strobes are ignored. Bits that are not loaded keep their old value.
- R8: When `inc_wr` and `inc_rd` are both high with no load, the write rule of R3 applies.
- R9: When `ld_hi_en` and `ld_lo_en` are high in the same cycle, both fields take their values from the same `ld_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_hi_en | input | 1 | Load the upper address field from `ld_byte` |
| ld_lo_en | input | 1 | Load the lower address byte from `ld_byte` |
| ld_byte | input | 8 | Byte to load |
| inc_wr | input | 1 | Step with the in-page wrap rule |
| inc_rd | input | 1 | Step with the whole-array wrap rule |
| ptr | output | ADDR_W | Current word address |

## Verification
The bench builds the block with the default width of 13 bits. At this width the high byte has three bits that must be dropped, which tests R6 at its boundary. The whole array is small enough that the wrap from 0x1FFF to zero happens within a few cycles of a load. A write burst of more than two pages' worth of steps shows that the row stays fixed through several in-page wraps. Same-cycle collisions of loads and the two increment kinds test the priority rules.

// File: rtl/wptr_pkg.sv
package wptr_pkg;
  localparam int PAGE_BITS = 5;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_PAGE  = 2'd1,
    STEP_ARRAY = 2'd2
  } step_kind_e;
endpackage

// File: rtl/wptr_loader.sv
module wptr_loader #(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              ld_hi_en,
  input  logic              ld_lo_en,
  input  logic [7:0]        ld_byte,
  output logic [ADDR_W-1:0] loaded,
  output logic              load_evt,
  output logic              hi_drop
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_field;

  // One assignment per upper address bit; the bits of the byte beyond the field are not used.
  for (genvar i = 0; i < HI_W; i++) begin : g_hi
    assign hi_field[i] = ld_hi_en ? ld_byte[i] : cur[8+i];
  end

  assign loaded   = {hi_field, (ld_lo_en ? ld_byte : cur[7:0])};
  assign load_evt = ld_hi_en | ld_lo_en;
  // Event: a high-byte load carries bits that will be discarded.
  assign hi_drop  = ld_hi_en && ((ld_byte >> HI_W) != 8'd0);
endmodule

// File: rtl/wptr_stepper.sv
module wptr_stepper
  import wptr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              inc_wr,
  input  logic              inc_rd,
  output logic [ADDR_W-1:0] stepped,
  output step_kind_e        kind,
  output logic              page_wrap,
  output logic              array_wrap
);
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_BITS], a[PAGE_BITS-1:0] + PAGE_BITS'(1)};
  endfunction

  function automatic logic [ADDR_W-1:0] array_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_comb begin
    if (inc_wr)      kind = STEP_PAGE;
    else if (inc_rd) kind = STEP_ARRAY;
    else             kind = STEP_NONE;
  end

  always_comb begin
    unique case (kind)
      STEP_PAGE:  stepped = page_next(cur);
      STEP_ARRAY: stepped = array_next(cur);
      default:    stepped = cur;
    endcase
  end

  assign page_wrap  = (kind == STEP_PAGE)  && (&cur[PAGE_BITS-1:0]);
  assign array_wrap = (kind == STEP_ARRAY) && (&cur);
endmodule

// File: rtl/word_ptr_ctr.sv
module word_ptr_ctr
  import wptr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi_en,
  input  logic              ld_lo_en,
  input  logic [7:0]        ld_byte,
  input  logic              inc_wr,
  input  logic              inc_rd,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] loaded;
  logic [ADDR_W-1:0] stepped;
  logic              load_evt;
  logic              hi_drop;
  logic              page_wrap;
  logic              array_wrap;
  logic              step_evt;
  step_kind_e        kind;

  wptr_loader #(.ADDR_W(ADDR_W)) u_loader (
    .cur      (ptr_q),
    .ld_hi_en (ld_hi_en),
    .ld_lo_en (ld_lo_en),
    .ld_byte  (ld_byte),
    .loaded   (loaded),
    .load_evt (load_evt),
    .hi_drop  (hi_drop)
  );

  wptr_stepper #(.ADDR_W(ADDR_W)) u_stepper (
    .cur        (ptr_q),
    .inc_wr     (inc_wr),
    .inc_rd     (inc_rd),
    .stepped    (stepped),
    .kind       (kind),
    .page_wrap  (page_wrap),
    .array_wrap (array_wrap)
  );

  assign step_evt = (kind != STEP_NONE) && !load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (load_evt) ptr_q <= loaded;
    else if (step_evt) ptr_q <= stepped;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/wptr_chk.sv
module wptr_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_hi_en,
  input logic              ld_lo_en,
  input logic [7:0]        ld_byte,
  input logic              inc_wr,
  input logic              inc_rd,
  input logic [ADDR_W-1:0] ptr,
  input logic              step_evt,
  input logic              hi_drop,
  input logic              page_wrap,
  input logic              array_wrap
);
  localparam int HI_W = ADDR_W - 8;

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> ptr == '0);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_hi_en && !ld_lo_en && !inc_wr && !inc_rd) |=> $stable(ptr));

  a_r3_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_wr && !ld_hi_en && !ld_lo_en) |=> ptr[ADDR_W-1:5] == $past(ptr[ADDR_W-1:5]));

  a_r3_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wrap && step_evt) |=> ptr[4:0] == 5'd0);

  a_r4_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_rd && !inc_wr && !ld_hi_en && !ld_lo_en) |=> ptr == $past(ptr) + ADDR_W'(1));

  a_r4_array_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (array_wrap && step_evt) |=> ptr == '0);

  a_r5_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_en |=> ptr[7:0] == $past(ld_byte));

  a_r6_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi_en |=> ptr[ADDR_W-1:8] == $past(ld_byte[HI_W-1:0]));

  a_r6_drop_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_drop && !ld_lo_en) |=> ptr[7:0] == $past(ptr[7:0]));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo_en && !ld_hi_en) |=> ptr[ADDR_W-1:8] == $past(ptr[ADDR_W-1:8]));

  a_r8_write_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_wr && inc_rd && !ld_hi_en && !ld_lo_en) |=> ptr[ADDR_W-1:5] == $past(ptr[ADDR_W-1:5]));
endmodule

bind word_ptr_ctr wptr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_hi_en   (ld_hi_en),
  .ld_lo_en   (ld_lo_en),
  .ld_byte    (ld_byte),
  .inc_wr     (inc_wr),
  .inc_rd     (inc_rd),
  .ptr        (ptr),
  .step_evt   (step_evt),
  .hi_drop    (hi_drop),
  .page_wrap  (page_wrap),
  .array_wrap (array_wrap)
);

// File: tb/tb_word_ptr_ctr.sv
module tb_word_ptr_ctr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int NVEC = 15;

  // {ld_hi, ld_lo, inc_wr, inc_rd, byte[7:0], expected ptr[15:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b1000, 8'h03, 16'h0300},  // R6 high load
    {4'b0100, 8'h1E, 16'h031E},  // R5 low load
    {4'b0010, 8'h00, 16'h031F},  // R3 write step
    {4'b0010, 8'h00, 16'h0300},  // R3 in-page wrap
    {4'b0100, 8'h1F, 16'h031F},  // R5
    {4'b0001, 8'h00, 16'h0320},  // R4 crosses page
    {4'b1000, 8'hFF, 16'h1F20},  // R6 upper byte bits dropped
    {4'b0100, 8'hFF, 16'h1FFF},  // R5
    {4'b0001, 8'h00, 16'h0000},  // R4 array wrap
    {4'b1100, 8'hAB, 16'h0BAB},  // R9 both fields
    {4'b0000, 8'h00, 16'h0BAB},  // R2 idle
    {4'b0101, 8'h10, 16'h0B10},  // R7 low load beats read step
    {4'b0100, 8'hFF, 16'h0BFF},  // R5
    {4'b0011, 8'h00, 16'h0BE0},  // R8 both steps, write rule
    {4'b1010, 8'h05, 16'h05E0}   // R7 high load beats write step
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_hi_en = 1'b0;
  logic          ld_lo_en = 1'b0;
  logic [7:0]    ld_byte = 8'h00;
  logic          inc_wr = 1'b0;
  logic          inc_rd = 1'b0;
  logic [AW-1:0] ptr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_ptr_ctr #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_hi_en(ld_hi_en), .ld_lo_en(ld_lo_en),
    .ld_byte(ld_byte), .inc_wr(inc_wr), .inc_rd(inc_rd), .ptr(ptr)
  );

  task automatic check(input string req, input logic [15:0] exp);
    logic [15:0] act;
    act = {{(16-AW){1'b0}}, ptr};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ptr actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic apply(input logic h, input logic l, input logic w, input logic r,
                       input logic [7:0] b);
    ld_hi_en = h; ld_lo_en = l; inc_wr = w; inc_rd = r; ld_byte = b;
    @(negedge clk);
    ld_hi_en = 1'b0; ld_lo_en = 1'b0; inc_wr = 1'b0; inc_rd = 1'b0; ld_byte = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);                 // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);                 // R1 after release, no strobe

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16]);
      check($sformatf("vec%0d", i), VEC[i][15:0]);
    end

    // R3: long write burst stays inside one row
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h07);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'hE0);
    model = 16'h07E0;
    for (int k = 0; k < 70; k++) begin
      apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
      model = {model[15:5], model[4:0] + 5'd1};
      check("R3", model);
    end

    // R4: read run through the top of the array
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'h1F);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'hF0);
    model = 16'h1FF0;
    for (int k = 0; k < 20; k++) begin
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
      model = (model + 16'd1) % 16'h2000;
      check("R4", model);
    end

    // R2: several idle cycles
    for (int k = 0; k < 5; k++) begin
      apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R2", model);
    end

    // R1: reset in the middle of activity
    apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h12);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h34);
    check("R6", 16'h1234);
    #1 rst_n = 1'b0;
    #1 check("R1", 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule